// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block sits between the decode output and the execute stage of an in-order, five-stage integer pipeline. For each of the two source operands of the instruction about to enter execute, it compares the source register number with the destination register of the three older instructions still in flight, in execute, memory access and write-back. It then picks either a bypassed result or the value read from the register file. When several older instructions target the same register, the closest one in program order supplies the value. Register zero always yields zero.

A load that sits in execute has no data yet. If the instruction behind it reads the load's destination, the block raises a stall request for one cycle. The surrounding pipeline holds the decode packet and puts a bubble into execute. In the next cycle the load has reached memory access, and its data is bypassed from there. Write-after-write and write-after-read cases need no logic, because every write-back happens in program order in the last stage.

The block is purely combinational from inputs to outputs. The clock and reset only time its built-in checks.

Top module: `fwd_unit`

## Requirements
- R1: When the execute stage is valid, writes a register, and its destination equals a nonzero source number, that operand output equals `ex_result`.
- R2: When memory access is the closest valid, writing stage whose destination equals a nonzero source number, that operand equals `mem_result`. This is also how load data reaches the consumer after the bubble.
- R3: When write-back is the only valid, writing stage whose destination equals a nonzero source number, that operand equals `wb_result`.
- R4: With no matching stage, each operand equals its register-file data input.
- R5: When more than one stage matches, priority is execute over memory access over write-back.
- R6: A source number of 0 gives an operand of zero, whatever the register-file data or the stage destinations.
- R7: A stage whose valid or write-enable is low is never used as a bypass source.
- R8: `stall_req` is 1 exactly when the decode packet is valid, execute holds a valid writing load, and its destination is nonzero and equals rs1 or rs2.
- R9: The two operands are resolved independently; one may be bypassed from one stage while the other uses another stage or the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the internal checks |
| rst_n | input | 1 | Synchronous active-low reset; disables the checks |
| id_valid | input | 1 | Decode-output packet valid |
| id_rs1 | input | REG_AW | Source register 1 number |
| id_rs2 | input | REG_AW | Source register 2 number |
| id_rs1_data | input | XLEN | Register-file value for source 1 |
| id_rs2_data | input | XLEN | Register-file value for source 2 |
| ex_valid | input | 1 | Execute packet valid |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_AW | Execute destination number |
| ex_result | input | XLEN | Execute result |
| mem_valid | input | 1 | Memory-access packet valid |
| mem_we | input | 1 | Memory-access instruction writes a register |
| mem_rd | input | REG_AW | Memory-access destination number |
| mem_result | input | XLEN | Memory-access result or load data |
| wb_valid | input | 1 | Write-back packet valid |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_rd | input | REG_AW | Write-back destination number |
| wb_result | input | XLEN | Write-back value |
| op1_out | output | XLEN | Resolved source 1 operand |
| op2_out | output | XLEN | Resolved source 2 operand |
| stall_req | output | 1 | Hold decode and insert one bubble into execute |

## Verification
The block holds no state, so a wrong priority decision or a wrong match shows up on `op1_out`/`op2_out` in the same cycle as the input pattern that triggers it. A missed interlock shows up in the same cycle as `stall_req` staying low while a load and its consumer are adjacent. The bench uses small register numbers so that multi-stage collisions, register zero, and cleared valid or write-enable flags occur often. Every cycle is compared against an independent behavioural model.

// File: rtl/fwd_pkg.sv
// Shared definitions for the operand bypass block.
// Assumes: one source-select encoding is used by every operand path.
package fwd_pkg;

    // Origin of a resolved operand, youngest source last.
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_WB  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_EX  = 2'd3
    } fwd_src_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_match.sv
// Compares one source register number with one stage's destination.
// Assumes: register 0 is hardwired to zero and is never a bypass target.
module fwd_match #(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_num,
    input  logic [REG_AW-1:0] dst_num,
    input  logic              stg_valid,
    input  logic              stg_we,
    output logic              hit
);

    // Hit when the stage really writes the register being read.
    always_comb begin
        hit = stg_valid && stg_we && (dst_num == src_num) && (src_num != '0);
    end

endmodule

// File: rtl/fwd_select.sv
// Chooses one operand value from the stage hits, youngest stage first.
// Assumes: the hit inputs already exclude register 0 and idle stages.
module fwd_select
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            src_is_zero,
    input  logic            hit_ex,
    input  logic            hit_mem,
    input  logic            hit_wb,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] ex_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] op_val
);

    fwd_src_e src;

    // Priority decode: execute, then memory access, then write-back.
    always_comb begin
        if (hit_ex)       src = SRC_EX;
        else if (hit_mem) src = SRC_MEM;
        else if (hit_wb)  src = SRC_WB;
        else              src = SRC_RF;
    end

    // Operand mux; register 0 is forced to zero.
    always_comb begin
        if (src_is_zero) begin
            op_val = '0;
        end else begin
            unique case (src)
                SRC_EX:  op_val = ex_val;
                SRC_MEM: op_val = mem_val;
                SRC_WB:  op_val = wb_val;
                default: op_val = rf_val;
            endcase
        end
    end

endmodule

// File: rtl/load_use_detect.sv
// Flags a load in execute whose result the decode-stage instruction reads.
// Assumes: the hit inputs come from the execute-stage comparators.
module load_use_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic id_valid,
    input  logic ex_is_load,
    input  logic hit_ex_op1,
    input  logic hit_ex_op2,
    output logic stall
);

    // One bubble request covers either or both operands.
    always_comb begin
        stall = id_valid && ex_is_load && (hit_ex_op1 || hit_ex_op2);
    end

    // R8: a stall is only ever raised for a load.
    a_r8_stall_only_load: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ex_is_load);

endmodule

// File: rtl/fwd_unit.sv
// Operand bypass and load-use interlock for a five-stage in-order pipeline.
// Resolves both source operands from the execute, memory-access or write-back
// result, or from the register file, and requests one bubble when a load in
// execute feeds the next instruction.
// Assumes: purely combinational data path; clk/rst_n only time the checks.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [XLEN-1:0]   id_rs1_data,
    input  logic [XLEN-1:0]   id_rs2_data,
    input  logic              ex_valid,
    input  logic              ex_we,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic [XLEN-1:0]   ex_result,
    input  logic              mem_valid,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic [XLEN-1:0]   mem_result,
    input  logic              wb_valid,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic [XLEN-1:0]   wb_result,
    output logic [XLEN-1:0]   op1_out,
    output logic [XLEN-1:0]   op2_out,
    output logic              stall_req
);

    logic [REG_AW-1:0] rs_a   [NUM_OPERANDS];
    logic [XLEN-1:0]   rf_a   [NUM_OPERANDS];
    logic [XLEN-1:0]   op_a   [NUM_OPERANDS];
    logic              hex_a  [NUM_OPERANDS];
    logic              hmem_a [NUM_OPERANDS];
    logic              hwb_a  [NUM_OPERANDS];

    // Gather per-operand inputs into arrays.
    always_comb begin
        rs_a[0] = id_rs1;
        rs_a[1] = id_rs2;
        rf_a[0] = id_rs1_data;
        rf_a[1] = id_rs2_data;
    end

    // One independent bypass path per operand.
    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_op
        fwd_match #(.REG_AW(REG_AW)) u_m_ex (
            .src_num(rs_a[g]), .dst_num(ex_rd), .stg_valid(ex_valid),
            .stg_we(ex_we), .hit(hex_a[g]));
        fwd_match #(.REG_AW(REG_AW)) u_m_mem (
            .src_num(rs_a[g]), .dst_num(mem_rd), .stg_valid(mem_valid),
            .stg_we(mem_we), .hit(hmem_a[g]));
        fwd_match #(.REG_AW(REG_AW)) u_m_wb (
            .src_num(rs_a[g]), .dst_num(wb_rd), .stg_valid(wb_valid),
            .stg_we(wb_we), .hit(hwb_a[g]));
        fwd_select #(.XLEN(XLEN)) u_sel (
            .src_is_zero(rs_a[g] == '0),
            .hit_ex(hex_a[g]), .hit_mem(hmem_a[g]), .hit_wb(hwb_a[g]),
            .rf_val(rf_a[g]), .ex_val(ex_result), .mem_val(mem_result),
            .wb_val(wb_result), .op_val(op_a[g]));
    end

    // Drive the operand outputs.
    always_comb begin
        op1_out = op_a[0];
        op2_out = op_a[1];
    end

    load_use_detect u_lud (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .ex_is_load(ex_is_load),
        .hit_ex_op1(hex_a[0]), .hit_ex_op2(hex_a[1]), .stall(stall_req));

    // R6: register 0 always reads as zero.
    a_r6_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0) |-> (op1_out == '0));
    // R5: an execute-stage match wins over any older stage.
    a_r5_ex_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_we && ex_rd == id_rs2 && id_rs2 != '0) |-> (op2_out == ex_result));
    // R7: with every stage idle the register file is used.
    a_r7_idle_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid && !mem_valid && !wb_valid && id_rs1 != '0) |-> (op1_out == id_rs1_data));
    // R8: a stall needs a valid consumer and a nonzero matching destination.
    a_r8_stall_match: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (id_valid && ex_valid && ex_we && ex_rd != '0 &&
                       (ex_rd == id_rs1 || ex_rd == id_rs2)));

endmodule

// File: tb/fwd_unit_tb_top.sv
// Bench: directed corner cases then random traffic, compared each cycle
// with a behavioural model.
module fwd_unit_tb_top;
    localparam int XLEN = 32;
    localparam int RAW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid, ex_valid, ex_we, ex_is_load, mem_valid, mem_we, wb_valid, wb_we;
    logic [RAW-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
    logic [XLEN-1:0] id_rs1_data, id_rs2_data, ex_result, mem_result, wb_result;
    logic [XLEN-1:0] op1_out, op2_out;
    logic stall_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fwd_unit #(.XLEN(XLEN), .REG_AW(RAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_data(id_rs1_data), .id_rs2_data(id_rs2_data),
        .ex_valid(ex_valid), .ex_we(ex_we), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
        .ex_result(ex_result), .mem_valid(mem_valid), .mem_we(mem_we), .mem_rd(mem_rd),
        .mem_result(mem_result), .wb_valid(wb_valid), .wb_we(wb_we), .wb_rd(wb_rd),
        .wb_result(wb_result), .op1_out(op1_out), .op2_out(op2_out), .stall_req(stall_req));

    // Behavioural model: list of older writers, youngest first.
    function automatic logic [XLEN-1:0] model_op(input logic [RAW-1:0] rs,
                                                 input logic [XLEN-1:0] rf);
        logic [XLEN-1:0] vals [$];
        logic [RAW-1:0]  dsts [$];
        if (rs == 0) return '0;
        if (ex_valid && ex_we)   begin vals.push_back(ex_result);  dsts.push_back(ex_rd);  end
        if (mem_valid && mem_we) begin vals.push_back(mem_result); dsts.push_back(mem_rd); end
        if (wb_valid && wb_we)   begin vals.push_back(wb_result);  dsts.push_back(wb_rd);  end
        foreach (dsts[i]) if (dsts[i] == rs) return vals[i];
        return rf;
    endfunction

    function automatic logic model_stall();
        return id_valid && ex_valid && ex_we && ex_is_load && ex_rd != 0 &&
               (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    task automatic check(input string req);
        logic [XLEN-1:0] e1, e2;
        logic es;
        e1 = model_op(id_rs1, id_rs1_data);
        e2 = model_op(id_rs2, id_rs2_data);
        es = model_stall();
        n_chk++;
        if (op1_out !== e1 || op2_out !== e2 || stall_req !== es) begin
            n_fail++;
            $display("FAIL %s: op1=%h op2=%h stall=%b expected op1=%h op2=%h stall=%b",
                     req, op1_out, op2_out, stall_req, e1, e2, es);
        end
    endtask

    task automatic idle_all();
        id_valid = 1; ex_valid = 0; ex_we = 0; ex_is_load = 0; mem_valid = 0; mem_we = 0;
        wb_valid = 0; wb_we = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
        id_rs1 = 1; id_rs2 = 2; id_rs1_data = 32'h1111_1111; id_rs2_data = 32'h2222_2222;
        ex_result = 32'hEEEE_0001; mem_result = 32'hAAAA_0002; wb_result = 32'hBBBB_0003;
    endtask

    // Apply at the falling edge, let logic settle, then compare.
    task automatic step(input string req);
        #2;
        check(req);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_all();
        repeat (3) @(negedge clk);
        step("R4 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        step("R4 no match");
        ex_valid = 1; ex_we = 1; ex_rd = 1; step("R1 ex bypass");
        idle_all(); mem_valid = 1; mem_we = 1; mem_rd = 2; step("R2 mem bypass");
        idle_all(); wb_valid = 1; wb_we = 1; wb_rd = 1; step("R3 wb bypass");
        idle_all(); ex_valid = 1; ex_we = 1; ex_rd = 1; mem_valid = 1; mem_we = 1; mem_rd = 1;
        wb_valid = 1; wb_we = 1; wb_rd = 1; step("R5 ex over mem over wb");
        ex_rd = 3; step("R5 mem over wb");
        idle_all(); id_rs1 = 0; id_rs1_data = 32'hDEAD_BEEF; ex_valid = 1; ex_we = 1;
        ex_rd = 0; step("R6 x0 reads zero");
        idle_all(); ex_valid = 1; ex_we = 0; ex_rd = 1; mem_valid = 0; mem_we = 1;
        mem_rd = 2; step("R7 disabled stages ignored");
        idle_all(); ex_valid = 1; ex_we = 1; ex_rd = 1; mem_valid = 1; mem_we = 1;
        mem_rd = 2; step("R9 independent operands");
        idle_all(); ex_valid = 1; ex_we = 1; ex_is_load = 1; ex_rd = 2; step("R8 load-use stall");
        id_valid = 0; step("R8 no stall without consumer");
        idle_all(); ex_valid = 1; ex_we = 1; ex_is_load = 1; ex_rd = 0; id_rs1 = 0;
        step("R8 no stall on x0");
        idle_all(); mem_valid = 1; mem_we = 1; mem_rd = 2; mem_result = 32'h0D0D_0D0D;
        step("R2 load data after bubble");
        for (int i = 0; i < 4000; i++) begin
            id_valid = 1'($urandom); ex_valid = 1'($urandom); ex_we = 1'($urandom);
            ex_is_load = 1'($urandom); mem_valid = 1'($urandom); mem_we = 1'($urandom);
            wb_valid = 1'($urandom); wb_we = 1'($urandom);
            id_rs1 = RAW'($urandom_range(0, 3)); id_rs2 = RAW'($urandom_range(0, 3));
            ex_rd = RAW'($urandom_range(0, 3)); mem_rd = RAW'($urandom_range(0, 3));
            wb_rd = RAW'($urandom_range(0, 3));
            id_rs1_data = $urandom; id_rs2_data = $urandom; ex_result = $urandom;
            mem_result = $urandom; wb_result = $urandom;
            step("R1 R2 R3 R5 R7 R8 R9 random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule